// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external 256K x 16 asynchronous static RAM. The host issues one word access at a time through a request/ready handshake. Each access carries a direction bit, an 18-bit word address, 16 bits of write data and a two-bit byte-lane enable. The block turns each accepted access into the active-low chip-select, write-strobe, output-enable and per-byte enable sequence that the memory needs. It also controls a split tri-state data bus: an output enable, an outgoing word and an incoming word.

Every minimum interval the memory imposes is expressed in nanoseconds as a parameter. Each interval becomes a whole number of clock cycles by rounding up against the clock period. The intervals are write-strobe width, write cycle, data setup, address access, output-enable access, byte-enable access, read cycle and bus release. At the default 4 ns clock, a read returns data on the fourth cycle after acceptance. A write holds the strobe low for two cycles with the output enable off throughout. After every read, a release gap passes before the block may drive the bus again.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, and in every cycle where `ready` is high, chip select and both lane enables are high (1), the write strobe and output enable are high, the bus is not driven (`mem_dq_oe`=0), and `rdata_valid` is 0.
- R2: An access is accepted at a rising clock edge where `req` and `ready` are both 1. `ready` is 0 in the cycle after acceptance and stays 0 until the access completes. Address, data, lane enables and direction are registered at acceptance, so later changes on the host inputs have no effect on that access.
- R3: A read (`wr`=0) holds the output enable low for at least ceil(T_OE/period) cycles (2 at defaults) before it captures `mem_dq_in`. `rdata_valid` is a one-cycle pulse that is first seen high 4 cycles after the acceptance edge at defaults.
- R4: `byte_en[0]`=1 selects bits 7:0 through `mem_lb_n`=0, and `byte_en[1]`=1 selects bits 15:8 through `mem_ub_n`=0. A deselected lane keeps its enable high, so a write leaves that lane's stored byte unchanged, and a read returns 8'h00 in that lane.
- R5: During a write the strobe stays low for at least ceil(T_WP/period) cycles (2 at defaults) with the output enable high for the whole pulse. The bus is driven with the registered word from the cycle before the strobe falls.
- R6: The block never drives the bus while the output enable is low. After the output enable rises at the end of a read, at least ceil(T_HZ/period) cycles (2 at defaults) pass with the output enable high before the bus is driven.
- R7: Chip select stays low for at least ceil(T_WC/period) cycles (3 at defaults) for each write.
- R8: The outgoing word is stable while the strobe is low, and it is still driven and unchanged in the cycle the strobe rises, since the memory commits on that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host access request |
| ready | output | 1 | Block idle and able to accept |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write word |
| byte_en | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rdata | output | 16 | Read word, deselected lanes zero |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is new |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_in | input | 16 | Data read from the memory |

## Verification
The assertions check the per-cycle pin relations on every cycle: standby while idle, no drive while the output enable is low, and the output enable held off and the bus driven while the strobe is low. They also check that the data word stays stable through the strobe rise and that `rdata_valid` is a single-cycle pulse. Only the bench scenarios can show the multi-cycle intervals and the stored contents. These are the strobe width, the write cycle length, the release gap after a read and the read latency. The stored contents show that deselected lanes keep their old bytes and that reads zero the lanes left out. The bench's memory model returns garbage until the output enable has been low long enough, so an early capture shows up as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int WORD_W = 16;
    localparam int LANES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_TURNAROUND,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } st_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int cycles_for(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // load in the cycle before the timed state; expires len cycles later
    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len - ONE;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_merge.sv
module sram_rd_merge
    import sram_ctl_pkg::*;
(
    input  logic [WORD_W-1:0] dq,
    input  logic [LANES-1:0]  lane_off,
    output logic [WORD_W-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = lane_off[i] ? 8'h00 : dq[8*i +: 8];
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int CLK_NS  = 4,
    parameter int T_WP_NS = 7,
    parameter int T_WC_NS = 10,
    parameter int T_DW_NS = 5,
    parameter int T_AA_NS = 10,
    parameter int T_OE_NS = 5,
    parameter int T_BA_NS = 5,
    parameter int T_RC_NS = 10,
    parameter int T_HZ_NS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  byte_en,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_dq_oe,
    output logic [WORD_W-1:0] mem_dq_out,
    input  logic [WORD_W-1:0] mem_dq_in
);
    // strobe width also covers write cycle (setup + pulse + recover) and data setup
    localparam int WP_CYC = max3(cycles_for(T_WP_NS, CLK_NS),
                                 cycles_for(T_WC_NS, CLK_NS) - 2,
                                 cycles_for(T_DW_NS, CLK_NS) - 1);
    // output-enable window; address already valid one setup cycle earlier
    localparam int RW_CYC = max3(max3(cycles_for(T_AA_NS, CLK_NS) - 1,
                                      cycles_for(T_OE_NS, CLK_NS),
                                      cycles_for(T_BA_NS, CLK_NS) - 1),
                                 cycles_for(T_RC_NS, CLK_NS) - 2, 1);
    localparam int TA_CYC = cycles_for(T_HZ_NS, CLK_NS);
    localparam int CNT_W  = $clog2(max3(WP_CYC, RW_CYC, TA_CYC) + 1);
    localparam logic [CNT_W-1:0] WP_LEN = CNT_W'(WP_CYC);
    localparam logic [CNT_W-1:0] RW_LEN = CNT_W'(RW_CYC);
    localparam logic [CNT_W-1:0] TA_LEN = CNT_W'(TA_CYC);

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [LANES-1:0]  be_n;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } regs_t;

    localparam regs_t R_RST = '{st: ST_IDLE, addr: '0, wdata: '0, be_n: '1,
                                rdata: '0, rvalid: 1'b0, ce_n: 1'b1,
                                we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    regs_t             r_d, r_q;
    logic              ld;
    logic [CNT_W-1:0]  ld_len;
    logic              expired;
    logic [WORD_W-1:0] lane_data;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .len     (ld_len),
        .expired (expired)
    );

    sram_rd_merge u_merge (
        .dq       (mem_dq_in),
        .lane_off (r_q.be_n),
        .merged   (lane_data)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        ld         = 1'b0;
        ld_len     = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = addr;
                    r_d.wdata = wdata;
                    r_d.be_n  = ~byte_en;
                    r_d.st    = wr ? ST_WR_SETUP : ST_RD_SETUP;
                end
            end
            ST_RD_SETUP: begin
                r_d.st = ST_RD_WAIT;
                ld     = 1'b1;
                ld_len = RW_LEN;
            end
            ST_RD_WAIT: begin
                if (expired) begin
                    r_d.st     = ST_RD_CAPTURE;
                    r_d.rdata  = lane_data;
                    r_d.rvalid = 1'b1;
                end
            end
            ST_RD_CAPTURE: begin
                r_d.st = ST_TURNAROUND;
                ld     = 1'b1;
                ld_len = TA_LEN;
            end
            ST_TURNAROUND: begin
                if (expired) r_d.st = ST_IDLE;
            end
            ST_WR_SETUP: begin
                r_d.st = ST_WR_PULSE;
                ld     = 1'b1;
                ld_len = WP_LEN;
            end
            ST_WR_PULSE: begin
                if (expired) r_d.st = ST_WR_RECOVER;
            end
            ST_WR_RECOVER: r_d.st = ST_IDLE;
            default:       r_d.st = ST_IDLE;
        endcase

        // pins registered from the state being entered
        r_d.ce_n  = (r_d.st == ST_IDLE) || (r_d.st == ST_TURNAROUND);
        r_d.oe_n  = (r_d.st != ST_RD_WAIT);
        r_d.we_n  = (r_d.st != ST_WR_PULSE);
        r_d.dq_oe = (r_d.st == ST_WR_SETUP) || (r_d.st == ST_WR_PULSE) ||
                    (r_d.st == ST_WR_RECOVER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= R_RST;
        else        r_q <= r_d;
    end

    assign ready       = (r_q.st == ST_IDLE);
    assign rdata       = r_q.rdata;
    assign rdata_valid = r_q.rvalid;
    assign mem_addr    = r_q.addr;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_we_n    = r_q.we_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_lb_n    = r_q.be_n[0] | r_q.ce_n;
    assign mem_ub_n    = r_q.be_n[1] | r_q.ce_n;
    assign mem_dq_oe   = r_q.dq_oe;
    assign mem_dq_out  = r_q.wdata;

    // R1: idle means standby with the bus released
    p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rdata_valid));

    // R2: acceptance closes the handshake next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    // R3: result strobe is a single pulse following an output-enable window
    p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);
    p_capture_after_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(!mem_oe_n));

    // R5: output enable off and bus driven throughout the strobe
    p_write_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

    // R6: never drive against the memory's outputs
    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe);

    // R8: data and address held through the committing strobe edge
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
    import sram_ctl_pkg::*;

    localparam int WP_MIN = 2;
    localparam int WC_MIN = 3;
    localparam int TA_MIN = 2;
    localparam int OE_MIN = 2;
    localparam int RD_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ready;
    logic        wr = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  byte_en = '0;
    logic [15:0] rdata;
    logic        rdata_valid;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBEEF;

    always #2 clk = ~clk;

    sram_ctl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr),
        .addr(addr), .wdata(wdata), .byte_en(byte_en), .rdata(rdata),
        .rdata_valid(rdata_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [15:0] mem    [logic [17:0]];
    logic [15:0] shadow [logic [17:0]];
    int   oe_cnt  = 0;
    logic we_prev = 1'b1;

    always @(negedge clk) begin
        logic [15:0] cur;
        logic [1:0]  lane_n;
        lane_n = {mem_ub_n, mem_lb_n};
        if (rst_n && !we_prev && mem_we_n) begin
            chk(mem_dq_oe, "R8 bus driven at strobe rise", 32'(mem_dq_oe), 1);
            if (!mem_ce_n) begin
                cur = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
                for (int l = 0; l < 2; l++)
                    if (!lane_n[l]) cur[8*l +: 8] = mem_dq_out[8*l +: 8];
                mem[mem_addr] = cur;
            end
        end
        we_prev = mem_we_n;
        oe_cnt  = mem_oe_n ? 0 : oe_cnt + 1;
        if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
            cur = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
            for (int l = 0; l < 2; l++)
                mem_dq_in[8*l +: 8] = lane_n[l] ? 8'hA5 :
                                      (oe_cnt >= OE_MIN ? cur[8*l +: 8] : 8'hDE);
        end else begin
            mem_dq_in = 16'hBEEF;
        end
    end

    // ---------------- interval monitor ----------------
    int   we_low = 0, ce_low = 0, oe_hi = 100;
    bit   wr_in_run = 0, oe_bad = 0, moved = 0;
    logic dq_oe_prev = 1'b0, rv_prev = 1'b0;
    logic [15:0] dq_seen = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                if (we_low != 0 && mem_dq_out != dq_seen) moved = 1;
                dq_seen = mem_dq_out;
                we_low++;
                wr_in_run = 1;
                if (!mem_oe_n) oe_bad = 1;
            end else if (we_low != 0) begin
                chk(we_low >= WP_MIN, "R5 strobe width", we_low, WP_MIN);
                chk(!oe_bad, "R5 output enable high during strobe", 32'(oe_bad), 0);
                chk(!moved && mem_dq_out == dq_seen, "R8 data stable through strobe",
                    mem_dq_out, dq_seen);
                we_low = 0; oe_bad = 0; moved = 0;
            end
            if (!mem_ce_n) ce_low++;
            else begin
                if (ce_low != 0 && wr_in_run)
                    chk(ce_low >= WC_MIN, "R7 write cycle length", ce_low, WC_MIN);
                ce_low = 0; wr_in_run = 0;
            end
            if (mem_dq_oe && !mem_oe_n)
                chk(0, "R6 bus driven with output enable low", 1, 0);
            oe_hi = mem_oe_n ? oe_hi + 1 : 0;
            if (mem_dq_oe && !dq_oe_prev)
                chk(oe_hi - 1 >= TA_MIN, "R6 release gap before drive", oe_hi - 1, TA_MIN);
            if (ready && !(mem_ce_n && mem_lb_n && mem_ub_n && !mem_dq_oe))
                chk(0, "R1 standby while idle", {mem_ce_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 4'b1110);
            if (rdata_valid && rv_prev)
                chk(0, "R3 rdata_valid longer than one cycle", 1, 0);
            dq_oe_prev = mem_dq_oe;
            rv_prev    = rdata_valid;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] data;
        int          acc;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rdata_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected rdata_valid", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(rdata == e.data, "R4 read word", rdata, e.data);
                chk(cyc - e.acc == RD_LAT, "R3 read latency", cyc - e.acc, RD_LAT);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        logic [15:0] cur;
        exp_t        e;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d; byte_en = be;
        cur = shadow.exists(a) ? shadow[a] : 16'h0000;
        if (w) begin
            for (int l = 0; l < 2; l++)
                if (be[l]) cur[8*l +: 8] = d[8*l +: 8];
            shadow[a] = cur;
        end else begin
            for (int l = 0; l < 2; l++)
                if (!be[l]) cur[8*l +: 8] = 8'h00;
            e.data = cur;
            e.acc  = cyc;
            exp_q.push_back(e);
        end
        @(negedge clk);
        chk(!ready, "R2 ready low after acceptance", 32'(ready), 0);
        // scramble host inputs: the registered copy must be used (R2)
        req = 1'b0; wr = ~w; addr = ~a; wdata = ~d; byte_en = ~be;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired, R1-style idle never reached: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", 32'(ready), 1);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111,
            "R1 control pins high in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1f);
        chk(!mem_dq_oe && !rdata_valid, "R1 bus released, no valid", {mem_dq_oe, rdata_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_ce_n, "R1 idle after reset release", {ready, mem_ce_n}, 2'b11);

        // full word write and read back
        do_op(1, 18'h00010, 16'h1234, 2'b11);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        // R4 low lane only
        do_op(1, 18'h00010, 16'hABCD, 2'b01);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        // R4 high lane only
        do_op(1, 18'h00010, 16'h5678, 2'b10);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        // R4 partial reads zero the deselected lane
        do_op(0, 18'h00010, 16'h0000, 2'b01);
        do_op(0, 18'h00010, 16'h0000, 2'b10);
        // R4 no lanes selected: stored word untouched
        do_op(1, 18'h00010, 16'hFFFF, 2'b00);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        // address extremes, write directly after read (R6 turnaround)
        do_op(1, 18'h3FFFF, 16'hC3A5, 2'b11);
        do_op(1, 18'h00000, 16'h0F0F, 2'b11);
        do_op(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1, 18'h2AAAA, 16'h9966, 2'b11);
        do_op(0, 18'h00000, 16'h0000, 2'b11);
        do_op(0, 18'h2AAAA, 16'h0000, 2'b11);
        // unwritten address reads zero
        do_op(0, 18'h15555, 16'h0000, 2'b11);
        // burst of alternating accesses
        for (int i = 0; i < 8; i++) begin
            do_op(1, 18'(i * 4099), 16'(16'h1111 * i + 16'h0101), 2'(i % 4));
            do_op(0, 18'(i * 4099), 16'h0000, 2'b11);
        end

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
        chk(ready && mem_ce_n, "R1 idle at end", {ready, mem_ce_n}, 2'b11);
        summary();
        $finish;
    end

endmodule